// File: doc/BRIEF.md
# Mode-Based Memory Space Mapper

This block extends the 16-bit address of a processor so that it can reach a 256K RAM. It takes the processor's user/system mode output and its bus status code. From these it produces two upper RAM address bits and a RAM select. Up to four 64K regions can then be told apart:

- system space and user space;
- instruction space and data space.

A two-bit control register sits at one I/O port, and software can read it back. One bit turns on the system/user split. The other bit turns on the instruction/data split.

Reset clears both bits, so every access falls into one shared 64K region. This lets loader code write program images with ordinary data stores before it turns either split on. The address bits are decoded combinationally from the current status inputs. Only the two enable bits are held in flip-flops.

Top module: `mem_space_mapper`

## Requirements
- R1: After reset both enable bits are 0. Reading the control port returns 0, and every memory access gives `ram_ahi` = 2'b00.
- R2: An I/O write to address `CTRL_PORT` (default 8'hF0) loads `io_wdata[0]` as the system/user enable and `io_wdata[1]` as the instruction/data enable. The new values apply from the next rising clock edge.
- R3: While `io_rd` is high and `io_addr` equals `CTRL_PORT`, `io_rdata` shows {6'b0, instruction/data enable, system/user enable}. At any other time `io_rdata` is 8'h00.
- R4: An I/O write to any other address leaves both enable bits unchanged.
- R5: For a memory access, `ram_ahi[1]` is 1 exactly when `user_mode` is 1 and the system/user enable is set.
- R6: For a memory access, `ram_ahi[0]` is 1 exactly when the status is an instruction fetch and the instruction/data enable is set. An instruction fetch is `bus_status[3:2]` = 2'b11, that is codes 4'hC to 4'hF.
- R7: Data codes (4'h8, 4'h9) and stack codes (4'hA, 4'hB) are data space, so they give `ram_ahi[0]` = 0 in every configuration.
- R8: A status code with `bus_status[3]` = 0 is a non-memory cycle, such as I/O, interrupt acknowledge, refresh or internal. It gives `ram_sel` = 0 and `ram_ahi` = 2'b00. Any code with `bus_status[3]` = 1 gives `ram_sel` = 1.
- R9: `ram_sel` and `ram_ahi` follow `bus_status` and `user_mode` in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data |
| user_mode | input | 1 | 1 = user mode, 0 = system mode |
| bus_status | input | 4 | Bus cycle status code |
| ram_sel | output | 1 | RAM access this cycle |
| ram_ahi | output | 2 | RAM address bits 17:16 |

## Verification
The bench walks every status code in each of the four enable settings, in both modes. This separates the mode bit from the fetch bit, and it shows whether each enable gates only its own bit. Randomly chosen codes, modes and control writes, some of them to wrong ports, test the decoding together with the register updates. Directed cases cover three points: the shared space right after reset, read strobes with a wrong address, and stack codes with the instruction/data split on.

// File: rtl/mem_space_mapper.sv
module mem_space_mapper #(
  parameter int         IO_AW     = 8,
  parameter int         IO_DW     = 8,
  parameter int         ST_W      = 4,
  parameter logic [7:0] CTRL_PORT = 8'hF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [IO_DW-1:0] io_wdata,
  output logic [IO_DW-1:0] io_rdata,
  input  logic             user_mode,
  input  logic [ST_W-1:0]  bus_status,
  output logic             ram_sel,
  output logic [1:0]       ram_ahi
);
  localparam logic [IO_AW-1:0] PORT = IO_AW'(CTRL_PORT);

  logic su_en, id_en;
  logic hit, is_mem, is_fetch;

  assign hit      = (io_addr == PORT);
  assign is_mem   = bus_status[ST_W-1];
  assign is_fetch = is_mem & bus_status[ST_W-2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      su_en <= 1'b0;
      id_en <= 1'b0;
    end else if (io_wr && hit) begin
      su_en <= io_wdata[0];
      id_en <= io_wdata[1];
    end

  assign io_rdata = (io_rd && hit) ? {{(IO_DW-2){1'b0}}, id_en, su_en} : '0;

  assign ram_sel    = is_mem;
  assign ram_ahi[1] = is_mem & user_mode & su_en;
  assign ram_ahi[0] = is_fetch & id_en;
endmodule

module mem_space_mapper_chk #(
  parameter int         IO_AW     = 8,
  parameter int         ST_W      = 4,
  parameter logic [7:0] CTRL_PORT = 8'hF0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             io_wr,
  input logic [IO_AW-1:0] io_addr,
  input logic [7:0]       io_wdata,
  input logic             user_mode,
  input logic [ST_W-1:0]  bus_status,
  input logic             ram_sel,
  input logic [1:0]       ram_ahi,
  input logic             su_en,
  input logic             id_en
);
  // R2
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == IO_AW'(CTRL_PORT)) |=> (su_en == $past(io_wdata[0]) && id_en == $past(io_wdata[1])));
  // R4
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && io_addr == IO_AW'(CTRL_PORT)) |=> ($stable(su_en) && $stable(id_en)));
  // R5
  user_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_ahi[1] |-> (user_mode && su_en));
  // R6
  fetch_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_ahi[0] |-> (bus_status[ST_W-1:ST_W-2] == 2'b11 && id_en));
  // R8
  nonmem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_status[ST_W-1] |-> (!ram_sel && ram_ahi == 2'b00));
  // R1
  unified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!su_en && !id_en) |-> (ram_ahi == 2'b00));
endmodule

bind mem_space_mapper mem_space_mapper_chk #(.IO_AW(IO_AW), .ST_W(ST_W), .CTRL_PORT(CTRL_PORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata[7:0]),
  .user_mode(user_mode), .bus_status(bus_status), .ram_sel(ram_sel), .ram_ahi(ram_ahi),
  .su_en(su_en), .id_en(id_en)
);

// File: tb/mem_space_mapper_test.sv
module mem_space_mapper_test;
  logic       clk = 0, rst_n = 0;
  logic       io_wr = 0, io_rd = 0;
  logic [7:0] io_addr = 0, io_wdata = 0, io_rdata;
  logic       user_mode = 0;
  logic [3:0] bus_status = 0;
  logic       ram_sel;
  logic [1:0] ram_ahi;
  int checks = 0, errors = 0;
  logic m_su = 0, m_id = 0;

  mem_space_mapper uut (.*);

  always #10 clk = ~clk;

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [2:0] exp_map(logic [3:0] st, logic um, logic su, logic id);
    logic mem = st[3];
    return {mem, mem & um & su, mem & st[2] & id};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    io_wr = 1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 0;
    if (a == 8'hF0) begin m_su = d[0]; m_id = d[1]; end
  endtask

  task automatic readback(string req);
    @(negedge clk);
    io_rd = 1; io_addr = 8'hF0;
    #1 chk(req, io_rdata, {6'b0, m_id, m_su});
    io_rd = 0;
  endtask

  task automatic probe(string req, logic [3:0] st, logic um);
    bus_status = st; user_mode = um;
    #1 chk(req, {5'b0, ram_sel, ram_ahi}, {5'b0, exp_map(st, um, m_su, m_id)});
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    readback("R1");
    for (int s = 0; s < 16; s++) probe("R1", 4'(s), 1'b1);
    rst_n = 1;
    readback("R1");
    @(negedge clk);
    for (int s = 0; s < 16; s++) probe("R1", 4'(s), 1'b1);

    for (int cfg = 0; cfg < 4; cfg++) begin
      do_write(8'hF0, 8'(cfg) | 8'hFC);
      readback("R2");
      for (int s = 0; s < 16; s++)
        for (int um = 0; um < 2; um++) begin
          @(negedge clk);
          if (s < 8) probe("R8", 4'(s), 1'(um));
          else if (s < 12) probe("R7", 4'(s), 1'(um));
          else probe("R6", 4'(s), 1'(um));
        end
    end

    do_write(8'hF0, 8'h01);
    do_write(8'hF1, 8'h02);
    readback("R4");
    do_write(8'h70, 8'h03);
    readback("R4");

    @(negedge clk);
    io_rd = 1; io_addr = 8'hF1;
    #1 chk("R3", io_rdata, 8'h00);
    io_rd = 0; io_addr = 8'hF0;
    #1 chk("R3", io_rdata, 8'h00);

    do_write(8'hF0, 8'h03);
    @(negedge clk);
    probe("R7", 4'hA, 1'b1);
    probe("R7", 4'hB, 1'b0);
    probe("R9", 4'hC, 1'b1);
    probe("R9", 4'h8, 1'b0);
    probe("R5", 4'h9, 1'b1);

    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 7) == 0) begin
        logic [7:0] a = ($urandom_range(0, 1) == 0) ? 8'hF0 : 8'($urandom);
        do_write(a, 8'($urandom));
        readback("R2");
      end
      @(negedge clk);
      probe("R5", 4'($urandom), 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule